// File: doc/BRIEF.md
# Peripheral Bus Handshake Translator

This block connects a 16-bit processor bus, which announces each bus cycle through a 4-bit status code, to a set of byte-wide peripherals that expect the older three-strobe handshake: an I/O request, a machine-cycle-one marker and a read strobe. The block watches the processor's address strobe. On the address strobe's rising edge it captures the status code, the read/write direction and the port-select bits of the multiplexed address/data bus. It then decodes those bits into one active-low chip enable per peripheral. The decode is split across several decoder banks.

While the data strobe is low, the block drives the peripheral strobes that suit the captured cycle type. I/O reads assert the I/O request and read strobes. I/O writes assert the I/O request alone. A vectored interrupt acknowledge asserts the I/O request together with the machine-cycle-one marker, so the peripherals can put their interrupt vector on the bus. A first-word opcode fetch asserts the machine-cycle-one marker alone. Peripherals still raise interrupts on their own shared open-drain line to the processor. That line does not pass through this block.

All inputs are treated as synchronous to `clk`. The edges of the address strobe are found by comparing each sample with the one taken a cycle earlier. The strobe outputs follow the data strobe combinationally, once the cycle type has been captured.

Top module: `pbh_translator`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge until a cycle is captured, `iorq_n`, `m1_n` and `rd_n` are high and every bit of `ce_n` is high, whatever the level of `ds_n`.
- R2: `status`, `ad_sel` and `rw` are captured at the clock edge where `as_n` is sampled high after being sampled low on the previous edge. Later changes to these inputs do not alter `ce_n` or the strobes until the next capture.
- R3: If the captured status is 4'b0010 (I/O reference), exactly one `ce_n` bit is low from the cycle after the capture: bit `ad_sel[3]*8 + ad_sel[2:0]`. `ad_sel[3]` picks the decoder bank and `ad_sel[2:0]` picks the device inside the bank.
- R4: In an I/O reference cycle with `rw` = 0 (write), `iorq_n` is low whenever `ds_n` is low, while `rd_n` and `m1_n` stay high.
- R5: In an I/O reference cycle with `rw` = 1 (read), `iorq_n` and `rd_n` are both low whenever `ds_n` is low, and `m1_n` stays high. `rd_n` is never low unless `iorq_n` is low.
- R6: If the captured status is 4'b0111 (vectored interrupt acknowledge), `iorq_n` and `m1_n` are low for the whole time `ds_n` is low. `rd_n` stays high and every `ce_n` bit stays high.
- R7: If the captured status is 4'b1100 (first-word opcode fetch), `m1_n` is low whenever `ds_n` is low. `iorq_n`, `rd_n` and every `ce_n` bit stay high.
- R8: Any other captured status drives no strobe and no chip enable low, whatever the level of `ds_n`.
- R9: While `ds_n` is high, `iorq_n`, `m1_n` and `rd_n` are all high.
- R10: At the clock edge where `as_n` is sampled low after being sampled high, the captured cycle is discarded. From the next cycle on, all chip enables and strobes are high until the next capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| status | input | 4 | Processor bus-cycle status code |
| as_n | input | 1 | Active-low address strobe |
| ds_n | input | 1 | Active-low data strobe |
| rw | input | 1 | Direction, 1 = read, 0 = write |
| ad_sel | input | 4 | Port-select bits taken from the address/data bus (bank bit on top) |
| ce_n | output | 16 | Active-low peripheral chip enables, one per device |
| iorq_n | output | 1 | Active-low I/O request strobe |
| m1_n | output | 1 | Active-low machine-cycle-one marker |
| rd_n | output | 1 | Active-low read strobe |

## Verification
The bench builds the block with its default parameters: a 3-bit device select and a 1-bit bank select, which gives two decoder banks of eight enables each. A directed sweep therefore reaches every one of the sixteen chip enables in both banks, as reads and as writes. The random phase mixes the four cycle types with unused status codes and varying data-strobe lengths. After each capture it scrambles the bus inputs, so any leak of a live input past the capture shows up on the outputs.

// File: rtl/pbh_pkg.sv
// Package: shared status codes and cycle kinds for the peripheral bus
// handshake translator. Assumes a 4-bit processor status field.
package pbh_pkg;

    localparam int ST_W = 4;

    localparam logic [ST_W-1:0] ST_IO_REF = 4'b0010;
    localparam logic [ST_W-1:0] ST_VI_ACK = 4'b0111;
    localparam logic [ST_W-1:0] ST_FETCH1 = 4'b1100;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_IO    = 2'd1,
        CYC_VIACK = 2'd2,
        CYC_FETCH = 2'd3
    } cyc_kind_e;

    // Map a status code to the kind of peripheral cycle it calls for.
    function automatic cyc_kind_e classify(input logic [ST_W-1:0] st);
        case (st)
            ST_IO_REF: classify = CYC_IO;
            ST_VI_ACK: classify = CYC_VIACK;
            ST_FETCH1: classify = CYC_FETCH;
            default:   classify = CYC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pbh_cycle_latch.sv
// Cycle latch: finds address-strobe edges by comparing with the previous
// sample. On the rising edge it captures cycle kind, direction and port
// select. On the falling edge it drops the captured cycle.
// Assumes as_n is synchronous to clk.
module pbh_cycle_latch
    import pbh_pkg::*;
#(
    parameter int SEL_TOTAL_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   as_n,
    input  logic [ST_W-1:0]        status,
    input  logic                   rw,
    input  logic [SEL_TOTAL_W-1:0] ad_sel,
    output cyc_kind_e              kind_q,
    output logic                   rd_q,
    output logic [SEL_TOTAL_W-1:0] sel_q
);

    logic as_q;
    logic as_rise;
    logic as_fall;

    // Edge detection against the previous address-strobe sample.
    always_comb begin
        as_rise = !as_q && as_n;
        as_fall = as_q && !as_n;
    end

    // Capture the cycle on the strobe rise; forget it on the strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_q   <= 1'b1;
            kind_q <= CYC_NONE;
            rd_q   <= 1'b0;
            sel_q  <= '0;
        end else begin
            as_q <= as_n;
            if (as_rise) begin
                kind_q <= classify(status);
                rd_q   <= rw;
                sel_q  <= ad_sel;
            end else if (as_fall) begin
                kind_q <= CYC_NONE;
            end
        end
    end

    // R2
    sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_q && as_n) |=> (sel_q == $past(ad_sel) && rd_q == $past(rw)));

    // R10
    cycle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (as_q && !as_n) |=> (kind_q == CYC_NONE));

endmodule

// File: rtl/pbh_ce_bank.sv
// One chip-enable decoder bank: when enabled and the bank field matches
// BANK_ID, it drives low the single enable picked by the device field.
// Assumes the enable input is already qualified by an I/O cycle.
module pbh_ce_bank #(
    parameter int SEL_W   = 3,
    parameter int BANK_W  = 1,
    parameter int BANK_ID = 0
) (
    input  logic                    en,
    input  logic [BANK_W-1:0]       bank,
    input  logic [SEL_W-1:0]        dev,
    output logic [(1<<SEL_W)-1:0]   ce_n
);

    localparam logic [BANK_W-1:0] MY_BANK = BANK_W'(BANK_ID);

    // Decode the device field once this bank is addressed.
    always_comb begin
        ce_n = '1;
        if (en && bank == MY_BANK) begin
            ce_n[dev] = 1'b0;
        end
    end

endmodule

// File: rtl/pbh_strobe_gen.sv
// Strobe generator: gates the data strobe into I/O request, machine-cycle-one
// and read strobes according to the captured cycle kind.
// Assumes kind and direction are held steady for the whole data-strobe window.
module pbh_strobe_gen
    import pbh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cyc_kind_e kind,
    input  logic      rd_q,
    input  logic      ds_n,
    output logic      iorq_n,
    output logic      m1_n,
    output logic      rd_n
);

    // Pick which strobes follow the data strobe in this cycle.
    always_comb begin
        iorq_n = 1'b1;
        m1_n   = 1'b1;
        rd_n   = 1'b1;
        case (kind)
            CYC_IO: begin
                iorq_n = ds_n;
                rd_n   = ds_n | !rd_q;
            end
            CYC_VIACK: begin
                iorq_n = ds_n;
                m1_n   = ds_n;
            end
            CYC_FETCH: begin
                m1_n = ds_n;
            end
            default: ;
        endcase
    end

    // R9
    strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ds_n |-> (iorq_n && m1_n && rd_n));

    // R5
    rd_needs_iorq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !iorq_n);

endmodule

// File: rtl/pbh_translator.sv
// Top level: the processor's status-coded bus goes in, a three-strobe
// peripheral handshake and per-device chip enables come out. It holds one
// cycle latch, one strobe generator and one decoder bank per bank value.
// Assumes all inputs are synchronous to clk.
module pbh_translator
    import pbh_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int BANK_W = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [3:0]                        status,
    input  logic                              as_n,
    input  logic                              ds_n,
    input  logic                              rw,
    input  logic [SEL_W+BANK_W-1:0]           ad_sel,
    output logic [(1<<(SEL_W+BANK_W))-1:0]    ce_n,
    output logic                              iorq_n,
    output logic                              m1_n,
    output logic                              rd_n
);

    localparam int TOTAL_W   = SEL_W + BANK_W;
    localparam int DEV_PER_B = 1 << SEL_W;
    localparam int NUM_BANKS = 1 << BANK_W;

    cyc_kind_e          kind_q;
    logic               rd_q;
    logic [TOTAL_W-1:0] sel_q;
    logic               io_en;

    pbh_cycle_latch #(
        .SEL_TOTAL_W(TOTAL_W)
    ) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .as_n   (as_n),
        .status (status),
        .rw     (rw),
        .ad_sel (ad_sel),
        .kind_q (kind_q),
        .rd_q   (rd_q),
        .sel_q  (sel_q)
    );

    // Chip-enable decoding is enabled only by an I/O reference cycle.
    always_comb io_en = (kind_q == CYC_IO);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pbh_ce_bank #(
            .SEL_W  (SEL_W),
            .BANK_W (BANK_W),
            .BANK_ID(b)
        ) u_bank (
            .en   (io_en),
            .bank (sel_q[TOTAL_W-1:SEL_W]),
            .dev  (sel_q[SEL_W-1:0]),
            .ce_n (ce_n[b*DEV_PER_B +: DEV_PER_B])
        );
    end

    pbh_strobe_gen u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (kind_q),
        .rd_q   (rd_q),
        .ds_n   (ds_n),
        .iorq_n (iorq_n),
        .m1_n   (m1_n),
        .rd_n   (rd_n)
    );

    // R3
    ce_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    // R6
    ack_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iorq_n && !m1_n) |-> (&ce_n && rd_n));

    // R7
    m1_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!m1_n) |-> (&ce_n));

endmodule

// File: tb/test_pbh_translator.sv
`timescale 1ns/1ps
module test_pbh_translator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  status = 4'h0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw = 1'b0;
    logic [3:0]  ad_sel = 4'h0;
    logic [15:0] ce_n;
    logic        iorq_n, m1_n, rd_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pbh_translator i_pbh_translator (
        .clk(clk), .rst_n(rst_n), .status(status), .as_n(as_n), .ds_n(ds_n),
        .rw(rw), .ad_sel(ad_sel), .ce_n(ce_n), .iorq_n(iorq_n),
        .m1_n(m1_n), .rd_n(rd_n)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected chip enables from the captured status and select (R3, R6, R7, R8).
    function automatic logic [15:0] exp_ce(input logic [3:0] st, input logic [3:0] sel);
        logic [15:0] v = 16'hFFFF;
        if (st == 4'b0010) v[{sel[3], sel[2:0]}] = 1'b0;
        return v;
    endfunction

    // Expected {iorq_n, m1_n, rd_n} (R4..R9).
    function automatic logic [2:0] exp_strb(input logic [3:0] st, input logic rdir,
                                            input logic ds);
        logic [2:0] v = 3'b111;
        if (!ds) begin
            case (st)
                4'b0010: v = rdir ? 3'b010 : 3'b011;
                4'b0111: v = 3'b001;
                4'b1100: v = 3'b101;
                default: v = 3'b111;
            endcase
        end
        return v;
    endfunction

    function automatic string tag(input logic [3:0] st, input logic rdir);
        if (st == 4'b0010) return rdir ? "R5 io read" : "R4 io write";
        if (st == 4'b0111) return "R6 vi ack";
        if (st == 4'b1100) return "R7 fetch";
        return "R8 other code";
    endfunction

    task automatic bus_cycle(input logic [3:0] st, input logic [3:0] sel,
                             input logic rdir, input int hold);
        @(negedge clk);
        as_n = 1'b0; status = st; ad_sel = sel; rw = rdir;
        @(negedge clk);
        #1 check("R10 cleared on strobe fall", {16'h0, ce_n}, 32'h0000FFFF);
        check("R10 strobes idle after fall", {29'h0, iorq_n, m1_n, rd_n}, 32'h7);
        as_n = 1'b1;
        @(negedge clk);
        // R2: scramble inputs after capture
        status = 4'($urandom); ad_sel = 4'($urandom); rw = 1'($urandom);
        #1 check("R3/R2 ce after capture", {16'h0, ce_n}, {16'h0, exp_ce(st, sel)});
        check("R9 strobes idle before ds", {29'h0, iorq_n, m1_n, rd_n}, 32'h7);
        ds_n = 1'b0;
        #1 check(tag(st, rdir), {29'h0, iorq_n, m1_n, rd_n},
                 {29'h0, exp_strb(st, rdir, 1'b0)});
        for (int i = 0; i < hold; i++) @(negedge clk);
        #1 check({tag(st, rdir), " hold"}, {29'h0, iorq_n, m1_n, rd_n},
                 {29'h0, exp_strb(st, rdir, 1'b0)});
        check("R2 ce held", {16'h0, ce_n}, {16'h0, exp_ce(st, sel)});
        ds_n = 1'b1;
        #1 check("R9 strobes idle after ds", {29'h0, iorq_n, m1_n, rd_n}, 32'h7);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        ds_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R1 reset ce", {16'h0, ce_n}, 32'h0000FFFF);
        check("R1 reset strobes", {29'h0, iorq_n, m1_n, rd_n}, 32'h7);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R1 after reset strobes", {29'h0, iorq_n, m1_n, rd_n}, 32'h7);
        ds_n = 1'b1;
        // Directed: every enable as read and write.
        for (int s = 0; s < 16; s++) begin
            bus_cycle(4'b0010, 4'(s), 1'b1, 1);
            bus_cycle(4'b0010, 4'(s), 1'b0, 0);
        end
        bus_cycle(4'b0111, 4'h5, 1'b1, 2);
        bus_cycle(4'b1100, 4'h9, 1'b1, 2);
        bus_cycle(4'b0000, 4'h3, 1'b1, 1);
        bus_cycle(4'b1111, 4'hA, 1'b0, 1);
        // Random mix.
        for (int n = 0; n < 300; n++) begin
            logic [3:0] st;
            int pick = int'($urandom_range(0, 4));
            case (pick)
                0: st = 4'b0010;
                1: st = 4'b0111;
                2: st = 4'b1100;
                3: st = 4'b0010;
                default: st = 4'($urandom);
            endcase
            bus_cycle(st, 4'($urandom), 1'($urandom), int'($urandom_range(0, 3)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule